// File: doc/BRIEF.md
# SPI FIFO, DMA and Interrupt Control

This block is the buffering and flow-control layer between a register bus and an SPI shift engine. A bus write to the data register pushes a word into the transmit store. The shift engine takes words from the head of that store. Each word the engine receives goes into the receive store, and a bus read of the data register pops it. A two-bit mode field decides, for each direction, whether the store is a multi-entry FIFO or a single-entry buffer without flow control.

Two DMA request lines, one for transmit and one for receive, run under a priority policy. With low priority a request drops for one cycle after each acknowledge. With high priority a request stays up until the FIFO is filled or drained. An interrupt flag records each completed word and is cleared by a strobe from the clear register. A mask and a "TX not full" enable combine the flag and the transmit room into the interrupt output.

The module is active only while its enable input is high and its soft-reset input is low. When it is not active, it flushes both stores and all internal flags. The configuration inputs are driven from outside and keep their values.

Top module: `spi_fifo_ctl`

## Requirements
- R1: While `cfg_en` is 0 or `cfg_srst` is 1, and after `rst_n` is released, the following hold from the next clock edge: both stores are empty (`tx_empty`=1, `rx_empty`=1, `tx_full`=0, `rx_full`=0), `int_flag`=0, `busy`=0, and both DMA requests are 0.
- R2: In FIFO operation a store holds `FIFO_DEPTH` (default 4) words and delivers them in the order they were written. `tx_full` reads 1 once the store holds `FIFO_DEPTH` words. A push while full is ignored.
- R3: `cfg_mode` bit 0 = 1 (modes 1 and 3) makes the TX store a single-entry buffer, and bit 1 = 1 (modes 2 and 3) does the same for the RX store. A single-entry buffer reads full while it holds a word, and a push into it replaces the word it holds.
- R4: `bus_rdata` updates on the clock edge that samples `bus_rd` while the RX store is non-empty. A read while the RX store is empty leaves the store unchanged and keeps the last value read.
- R5: `busy` is 1 when the TX store is not empty and the RX store is not a full FIFO. A full single-entry RX buffer does not suspend transfers. `eng_tx_take` pops the TX store only while `busy` is 1.
- R6: `int_flag` is set on the edge after `eng_rx_valid` and holds until a `bus_clr` strobe. If both come in the same cycle, the flag is set.
- R7: `irq` = (`int_flag` AND `cfg_irq_mask`) OR (`cfg_txnf_irq` AND TX not full AND the module active).
- R8: With `cfg_prio`=0, a DMA request is 0 during the cycle after its acknowledge, and then follows its condition again. The TX condition is "TX not full"; the RX condition is "RX not empty".
- R9: With `cfg_prio`=1, an acknowledge does not lower a request. It stays at 1 until the TX store is full, or until the RX store is empty.
- R10: In mode 3 with `cfg_dma_tx_sel`=0, the TX request rises on the edge after a completed word (`eng_rx_valid`). A TX acknowledge or a bus write withdraws it. With `cfg_dma_tx_sel`=1, the TX request follows "TX buffer not full".

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Module enable; 0 flushes stores and flags |
| cfg_srst | input | 1 | Soft reset; 1 flushes stores and flags |
| cfg_mode | input | 2 | Store mode: bit 0 single TX, bit 1 single RX |
| cfg_prio | input | 1 | DMA priority policy |
| cfg_irq_mask | input | 1 | Gates `int_flag` onto `irq` |
| cfg_txnf_irq | input | 1 | Raises `irq` while TX not full |
| cfg_dma_tx_sel | input | 1 | Mode 3 TX request trigger select |
| bus_wr | input | 1 | Data register write strobe (TX push) |
| bus_wdata | input | DATA_W | Write data |
| bus_rd | input | 1 | Data register read strobe (RX pop) |
| bus_rdata | output | DATA_W | Last word read from RX |
| bus_clr | input | 1 | Clear-register write strobe |
| eng_tx_data | output | DATA_W | TX head offered to the shift engine |
| eng_tx_take | input | 1 | Engine takes the TX head |
| eng_rx_valid | input | 1 | Engine finished a word |
| eng_rx_data | input | DATA_W | Word received by the engine |
| dma_tx_ack | input | 1 | DMA TX acknowledge |
| dma_rx_ack | input | 1 | DMA RX acknowledge |
| dma_tx_req | output | 1 | DMA TX request |
| dma_rx_req | output | 1 | DMA RX request |
| tx_full | output | 1 | TX store cannot take another word |
| tx_empty | output | 1 | TX store empty |
| rx_full | output | 1 | RX store full |
| rx_empty | output | 1 | RX store empty |
| busy | output | 1 | A transfer may proceed |
| int_flag | output | 1 | Sticky interrupt flag |
| irq | output | 1 | Interrupt output |

## Verification
The bench pushes one word past the FIFO depth. A design that accepted it would deliver a fifth, unexpected word, or the heads would come out in the wrong order. It reads from an empty RX store, where a design that moved the pointer would return stale or garbage data instead of the last value. It fills the RX FIFO with TX data pending and checks that `busy` drops, then repeats this with a single-entry RX buffer, where suspending would stall the link. It also checks the following:
- A clear strobe that arrives with a new word must not lose the flag.
- A low-priority acknowledge must open a one-cycle gap, and a high-priority one must not.
- In mode 3 the TX request must follow the selected trigger.

// File: rtl/spi_fctl_pkg.sv
package spi_fctl_pkg;

   // Store configuration: bit 0 makes TX single-entry, bit 1 makes RX single-entry
   typedef enum logic [1:0] {
      MODE_BOTH_FIFO = 2'd0,
      MODE_RX_FIFO   = 2'd1,
      MODE_TX_FIFO   = 2'd2,
      MODE_NO_FIFO   = 2'd3
   } fifo_mode_e;

   localparam int unsigned DMA_CH_TX = 0;
   localparam int unsigned DMA_CH_RX = 1;
   localparam int unsigned DMA_NCH   = 2;

endpackage

// File: rtl/sfc_fifo.sv
module sfc_fifo #(
   parameter int unsigned WIDTH = 32,
   parameter int unsigned DEPTH = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             single,
   input  logic             push,
   input  logic             pop,
   input  logic [WIDTH-1:0] wdata,
   output logic [WIDTH-1:0] head,
   output logic             full,
   output logic             empty
);

   localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int unsigned CW = AW + 1;

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("sfc_fifo: DEPTH must be a power of two, at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("sfc_fifo: WIDTH must be positive");
   end

   logic [WIDTH-1:0] mem [DEPTH];
   logic [AW-1:0]    wr_ptr, rd_ptr;
   logic [CW-1:0]    cnt;
   logic             do_push, do_pop, do_over;

   assign empty   = (cnt == '0);
   assign full    = single ? (cnt != '0) : (cnt == CW'(DEPTH));
   assign do_pop  = pop & ~empty;
   assign do_push = push & (~full | (single & do_pop));
   assign do_over = push & single & full & ~do_pop;
   assign head    = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (!flush) begin
         if (do_push)
            mem[wr_ptr] <= wdata;
         else if (do_over)
            mem[rd_ptr] <= wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         cnt    <= '0;
      end else if (flush) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         cnt    <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_ptr + AW'(1);
         if (do_pop)  rd_ptr <= rd_ptr + AW'(1);
         cnt <= cnt + CW'(do_push) - CW'(do_pop);
      end
   end

   p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CW'(DEPTH));

   p_single_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (single && cnt <= CW'(1)) |=> (!single || cnt <= CW'(1)));

   p_pop_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (empty && !push) |=> empty);

   p_flush_r1: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (empty && !full));

endmodule

// File: rtl/sfc_dmareq.sv
module sfc_dmareq #(
   parameter int unsigned NCH = 2
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           flush,
   input  logic           prio,
   input  logic [NCH-1:0] cond,
   input  logic [NCH-1:0] ack,
   output logic [NCH-1:0] req
);

   if (NCH < 1) begin : g_bad_nch
      $error("sfc_dmareq: NCH must be positive");
   end

   for (genvar i = 0; i < NCH; i++) begin : g_ch
      logic hold_r;

      // Low priority: one dead cycle after every acknowledge
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     hold_r <= 1'b0;
         else if (flush) hold_r <= 1'b0;
         else            hold_r <= ack[i] & ~prio;
      end

      assign req[i] = cond[i] & (prio | ~hold_r);

      p_lo_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
         (!prio && ack[i] && !flush) |=> (prio || !req[i]));

      p_hi_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
         (prio && ack[i] && req[i] && !flush) |=> (req[i] || !cond[i] || !prio));
   end

endmodule

// File: rtl/spi_fifo_ctl.sv
module spi_fifo_ctl
   import spi_fctl_pkg::*;
#(
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned FIFO_DEPTH = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_en,
   input  logic              cfg_srst,
   input  logic [1:0]        cfg_mode,
   input  logic              cfg_prio,
   input  logic              cfg_irq_mask,
   input  logic              cfg_txnf_irq,
   input  logic              cfg_dma_tx_sel,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_rd,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              bus_clr,
   output logic [DATA_W-1:0] eng_tx_data,
   input  logic              eng_tx_take,
   input  logic              eng_rx_valid,
   input  logic [DATA_W-1:0] eng_rx_data,
   input  logic              dma_tx_ack,
   input  logic              dma_rx_ack,
   output logic              dma_tx_req,
   output logic              dma_rx_req,
   output logic              tx_full,
   output logic              tx_empty,
   output logic              rx_full,
   output logic              rx_empty,
   output logic              busy,
   output logic              int_flag,
   output logic              irq
);

   if (DATA_W < 8) begin : g_bad_dw
      $error("spi_fifo_ctl: DATA_W must be at least 8");
   end

   fifo_mode_e           mode;
   logic                 active, flush;
   logic                 tx_sgl, rx_sgl;
   logic [DATA_W-1:0]    rx_head;
   logic                 int_r, done_pend, rdata_upd;
   logic [DMA_NCH-1:0]   dma_cond, dma_ack, dma_req;
   logic                 tx_cond;
   logic [DATA_W-1:0]    rdata_r;

   assign mode   = fifo_mode_e'(cfg_mode);
   assign active = cfg_en & ~cfg_srst;
   assign flush  = ~active;
   assign tx_sgl = (mode == MODE_RX_FIFO) || (mode == MODE_NO_FIFO);
   assign rx_sgl = (mode == MODE_TX_FIFO) || (mode == MODE_NO_FIFO);

   // Transfers pause only on a full RX FIFO; a single-entry RX buffer is overwritten
   assign busy = active & ~tx_empty & ~(rx_full & ~rx_sgl);

   sfc_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) u_tx (
      .clk   (clk),
      .rst_n (rst_n),
      .flush (flush),
      .single(tx_sgl),
      .push  (bus_wr),
      .pop   (eng_tx_take & busy),
      .wdata (bus_wdata),
      .head  (eng_tx_data),
      .full  (tx_full),
      .empty (tx_empty)
   );

   sfc_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) u_rx (
      .clk   (clk),
      .rst_n (rst_n),
      .flush (flush),
      .single(rx_sgl),
      .push  (eng_rx_valid),
      .pop   (bus_rd),
      .wdata (eng_rx_data),
      .head  (rx_head),
      .full  (rx_full),
      .empty (rx_empty)
   );

   // Sticky interrupt flag: a new word wins over a clear in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            int_r <= 1'b0;
      else if (flush)        int_r <= 1'b0;
      else if (eng_rx_valid) int_r <= 1'b1;
      else if (bus_clr)      int_r <= 1'b0;
   end
   assign int_flag = int_r;
   assign irq      = (int_r & cfg_irq_mask) | (cfg_txnf_irq & ~tx_full & active);

   // Completed-transfer trigger for the no-FIFO TX request
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     done_pend <= 1'b0;
      else if (flush)                 done_pend <= 1'b0;
      else if (eng_rx_valid)          done_pend <= 1'b1;
      else if (dma_tx_ack || bus_wr)  done_pend <= 1'b0;
   end

   assign rdata_upd = bus_rd & ~rx_empty;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         rdata_r <= '0;
      else if (flush)     rdata_r <= '0;
      else if (rdata_upd) rdata_r <= rx_head;
   end
   assign bus_rdata = rdata_r;

   assign tx_cond = (mode == MODE_NO_FIFO && !cfg_dma_tx_sel) ? done_pend : ~tx_full;

   assign dma_cond[DMA_CH_TX] = tx_cond & active;
   assign dma_cond[DMA_CH_RX] = ~rx_empty & active;
   assign dma_ack[DMA_CH_TX]  = dma_tx_ack;
   assign dma_ack[DMA_CH_RX]  = dma_rx_ack;

   sfc_dmareq #(.NCH(DMA_NCH)) u_dma (
      .clk  (clk),
      .rst_n(rst_n),
      .flush(flush),
      .prio (cfg_prio),
      .cond (dma_cond),
      .ack  (dma_ack),
      .req  (dma_req)
   );

   assign dma_tx_req = dma_req[DMA_CH_TX];
   assign dma_rx_req = dma_req[DMA_CH_RX];

   p_flag_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (int_flag && !bus_clr && active) |=> int_flag);

   p_flag_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_rx_valid && active) |=> int_flag);

   p_rd_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_empty && active) |=> $stable(bus_rdata));

   p_suspend_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_full && !rx_sgl) |-> !busy);

endmodule

// File: tb/spi_fifo_ctl_tb.sv
`timescale 1ns/1ps
module spi_fifo_ctl_tb;

   localparam int W = 32;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_en = 0, cfg_srst = 0, cfg_prio = 0, cfg_irq_mask = 0, cfg_txnf_irq = 0, cfg_dma_tx_sel = 0;
   logic [1:0] cfg_mode = 2'd0;
   logic bus_wr = 0, bus_rd = 0, bus_clr = 0;
   logic [W-1:0] bus_wdata = '0, eng_rx_data = '0;
   logic eng_tx_take = 0, eng_rx_valid = 0, dma_tx_ack = 0, dma_rx_ack = 0;
   logic [W-1:0] bus_rdata, eng_tx_data;
   logic dma_tx_req, dma_rx_req, tx_full, tx_empty, rx_full, rx_empty, busy, int_flag, irq;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   spi_fifo_ctl #(.DATA_W(W), .FIFO_DEPTH(4)) u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_srst(cfg_srst), .cfg_mode(cfg_mode),
      .cfg_prio(cfg_prio), .cfg_irq_mask(cfg_irq_mask), .cfg_txnf_irq(cfg_txnf_irq),
      .cfg_dma_tx_sel(cfg_dma_tx_sel), .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rd(bus_rd),
      .bus_rdata(bus_rdata), .bus_clr(bus_clr), .eng_tx_data(eng_tx_data), .eng_tx_take(eng_tx_take),
      .eng_rx_valid(eng_rx_valid), .eng_rx_data(eng_rx_data), .dma_tx_ack(dma_tx_ack),
      .dma_rx_ack(dma_rx_ack), .dma_tx_req(dma_tx_req), .dma_rx_req(dma_rx_req), .tx_full(tx_full),
      .tx_empty(tx_empty), .rx_full(rx_full), .rx_empty(rx_empty), .busy(busy),
      .int_flag(int_flag), .irq(irq)
   );

   // kind: 0 = bus write (exp = {tx_full,tx_empty}), 1 = engine word (exp = TX head), 2 = bus read (exp = rdata)
   localparam logic [65:0] TBL [17] = '{
      {2'd0, 32'hA1A1_0001, 32'd0},
      {2'd0, 32'hA2A2_0002, 32'd0},
      {2'd0, 32'hA3A3_0003, 32'd0},
      {2'd0, 32'hA4A4_0004, 32'd2},
      {2'd0, 32'hA5A5_0005, 32'd2},
      {2'd1, 32'hB1B1_0011, 32'hA1A1_0001},
      {2'd1, 32'hB2B2_0012, 32'hA2A2_0002},
      {2'd2, 32'd0,         32'hB1B1_0011},
      {2'd1, 32'hB3B3_0013, 32'hA3A3_0003},
      {2'd1, 32'hB4B4_0014, 32'hA4A4_0004},
      {2'd2, 32'd0,         32'hB2B2_0012},
      {2'd2, 32'd0,         32'hB3B3_0013},
      {2'd2, 32'd0,         32'hB4B4_0014},
      {2'd2, 32'd0,         32'hB4B4_0014},
      {2'd0, 32'hC1C1_0021, 32'd0},
      {2'd1, 32'hB5B5_0015, 32'hC1C1_0021},
      {2'd2, 32'd0,         32'hB5B5_0015}
   };

   task automatic cyc();
      @(negedge clk);
   endtask

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [31:0] d);
      bus_wr = 1; bus_wdata = d; cyc(); bus_wr = 0;
   endtask

   task automatic rd();
      bus_rd = 1; cyc(); bus_rd = 0;
   endtask

   task automatic rxw(input logic [31:0] d);
      eng_rx_valid = 1; eng_rx_data = d; cyc(); eng_rx_valid = 0;
   endtask

   task automatic flush_all();
      cfg_srst = 1; cyc(); cfg_srst = 0; cyc();
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      repeat (3) cyc();
      rst_n = 1;
      cyc();
      // R1 reset state with module off
      chk("R1 tx_empty", tx_empty, 1);
      chk("R1 rx_empty", rx_empty, 1);
      chk("R1 full flags", {tx_full, rx_full}, 0);
      chk("R1 busy/int", {busy, int_flag, irq}, 0);
      chk("R1 dma", {dma_tx_req, dma_rx_req}, 0);

      cfg_en = 1; cfg_mode = 2'd0; cyc();

      // R2 R4 table walk in mode 0
      for (int i = 0; i < 17; i++) begin
         logic [1:0]  k;
         logic [31:0] v, e;
         k = TBL[i][65:64]; v = TBL[i][63:32]; e = TBL[i][31:0];
         case (k)
            2'd0: begin
               wr(v);
               chk($sformatf("R2 table row %0d status", i), {tx_full, tx_empty}, e);
            end
            2'd1: begin
               chk($sformatf("R2 table row %0d head", i), eng_tx_data, e);
               chk($sformatf("R5 table row %0d busy", i), busy, 1);
               eng_tx_take = 1; eng_rx_valid = 1; eng_rx_data = v; cyc();
               eng_tx_take = 0; eng_rx_valid = 0;
            end
            default: begin
               rd();
               chk($sformatf("R4 table row %0d rdata", i), bus_rdata, e);
            end
         endcase
      end
      chk("R4 rx_empty after table", rx_empty, 1);

      // R6 interrupt flag
      bus_clr = 1; cyc(); bus_clr = 0;
      chk("R6 cleared", int_flag, 0);
      rxw(32'hD1); chk("R6 set", int_flag, 1);
      cyc(); chk("R6 held", int_flag, 1);
      bus_clr = 1; eng_rx_valid = 1; eng_rx_data = 32'hD2; cyc(); bus_clr = 0; eng_rx_valid = 0;
      chk("R6 set wins over clear", int_flag, 1);

      // R7 interrupt output
      chk("R7 masked", irq, 0);
      cfg_irq_mask = 1; cyc(); chk("R7 unmasked", irq, 1);
      bus_clr = 1; cyc(); bus_clr = 0; chk("R7 flag cleared", irq, 0);
      cfg_txnf_irq = 1; cyc(); chk("R7 tx not full", irq, 1);
      for (int i = 0; i < 4; i++) wr(32'hE0 + i);
      chk("R7 tx full", irq, 0);
      rxw(32'hD3);
      flush_all();
      // R1 soft reset flush
      chk("R1 srst tx_empty", tx_empty, 1);
      chk("R1 srst rx_empty", rx_empty, 1);
      chk("R1 srst int", int_flag, 0);
      cfg_txnf_irq = 0; cfg_irq_mask = 0;

      // R5 suspension on full RX FIFO
      for (int i = 0; i < 4; i++) rxw(32'hF0 + i);
      chk("R5 rx_full", rx_full, 1);
      wr(32'h5A5A);
      chk("R5 suspended", busy, 0);
      rd();
      chk("R5 resumed", busy, 1);
      chk("R4 first rx", bus_rdata, 32'hF0);
      flush_all();

      // R3 single-entry TX (mode 1)
      cfg_mode = 2'd1; cyc();
      wr(32'h11); chk("R3 tx single full", tx_full, 1);
      wr(32'h22); chk("R3 overwrite", eng_tx_data, 32'h22);
      eng_tx_take = 1; cyc(); eng_tx_take = 0;
      chk("R3 tx drained", tx_empty, 1);
      flush_all();

      // R3 R5 single-entry RX (mode 2)
      cfg_mode = 2'd2; cyc();
      rxw(32'h33); chk("R3 rx single full", rx_full, 1);
      rxw(32'h44);
      wr(32'h55);
      chk("R5 no suspend single rx", busy, 1);
      rd();
      chk("R3 rx overwrite", bus_rdata, 32'h44);
      chk("R3 rx drained", rx_empty, 1);
      flush_all();

      // R8 low priority
      cfg_mode = 2'd0; cfg_prio = 0; cyc();
      chk("R8 tx req up", dma_tx_req, 1);
      dma_tx_ack = 1; bus_wr = 1; bus_wdata = 32'h66; cyc(); dma_tx_ack = 0; bus_wr = 0;
      chk("R8 tx gap", dma_tx_req, 0);
      cyc(); chk("R8 tx back", dma_tx_req, 1);
      rxw(32'h71); rxw(32'h72);
      chk("R8 rx req up", dma_rx_req, 1);
      dma_rx_ack = 1; bus_rd = 1; cyc(); dma_rx_ack = 0; bus_rd = 0;
      chk("R8 rx gap", dma_rx_req, 0);
      cyc(); chk("R8 rx back", dma_rx_req, 1);
      flush_all();

      // R9 high priority
      cfg_prio = 1; cyc();
      chk("R9 tx req up", dma_tx_req, 1);
      for (int i = 0; i < 4; i++) begin
         dma_tx_ack = 1; bus_wr = 1; bus_wdata = 32'h80 + i; cyc(); dma_tx_ack = 0; bus_wr = 0;
         chk($sformatf("R9 tx req after %0d", i + 1), dma_tx_req, (i < 3) ? 1 : 0);
      end
      rxw(32'h91); rxw(32'h92);
      for (int i = 0; i < 2; i++) begin
         dma_rx_ack = 1; bus_rd = 1; cyc(); dma_rx_ack = 0; bus_rd = 0;
         chk($sformatf("R9 rx req after %0d", i + 1), dma_rx_req, (i < 1) ? 1 : 0);
      end
      flush_all();

      // R10 mode 3 TX request trigger
      cfg_prio = 0; cfg_mode = 2'd3; cfg_dma_tx_sel = 0; cyc();
      chk("R10 idle", dma_tx_req, 0);
      rxw(32'hA0); chk("R10 done raises", dma_tx_req, 1);
      dma_tx_ack = 1; cyc(); dma_tx_ack = 0;
      chk("R10 ack lowers", dma_tx_req, 0);
      cyc(); chk("R10 stays low", dma_tx_req, 0);
      cfg_dma_tx_sel = 1; cyc();
      chk("R10 free raises", dma_tx_req, 1);
      wr(32'hA1); chk("R10 full lowers", dma_tx_req, 0);
      flush_all();

      done = 1;
      summary();
      $finish;
   end

endmodule